// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block joins two parallel data ports, A and B, each `WIDTH` bits wide (18 by default), and carries data across in both directions. Every direction has one storage element per bit. All bits of a direction share one control set: an output enable, a latch enable and a capture clock. With the latch enable high, the storage is transparent and the far port follows the near port within the same cycle. With the latch enable low, the storage holds its value, and it loads new data only on a rising edge of that direction's capture clock. The A-to-B enable is active high. The B-to-A enable is active low.

Each port appears at the boundary as three separate signals: an input data vector, an output data vector and an output-enable bit. Each input bit also has a "driven" flag, which tells the block whether the external bus actively drives that bit. When the bus-hold option is set, an undriven bit keeps the last level it had while it was driven. When the option is clear, an undriven bit reads as 0. The capture clocks and the latch enables are sampled on the system clock. A capture fires when a capture clock is seen low at one system edge and high at the next, while the latch enable is low. The block does not resolve contention when both directions drive at once. Each direction works independently.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: With `ab_le`=1 and `ab_oe`=1, `b_out` equals the effective A input in the same cycle. The effective input is `a_in` for bits whose `a_drv` bit is 1.
- R2: With `ab_le`=0, a rising `ab_clk` stores the effective A input at the system edge that first samples `ab_clk` high, provided the previous edge sampled it low. `b_out` shows that value after this edge.
- R3: With `ab_le`=0 and `ab_clk` steady, whether high or low, `b_out` keeps its stored value whatever `a_in` does.
- R4: When `ab_le` falls, the storage keeps the A value sampled at the last system edge with `ab_le`=1. The fall of `ab_le` never causes a capture by itself. If `ab_clk` is already high when `ab_le` falls, it causes no capture either.
- R5: `ab_oe` is active high. While it is 0, `b_oe`=0 and `b_out`=0. Storage still loads while the output is disabled, and the value appears once the output is enabled again.
- R6: B-to-A works the same way using `ba_le` and `ba_clk`. Its enable `ba_oe_n` is active low: while it is 1, `a_oe`=0 and `a_out`=0.
- R7: With `BUS_HOLD`=1, an input bit whose driven flag is 0 reads as the last value it had while driven. With `BUS_HOLD`=0, such a bit reads as 0.
- R8: Reset clears both storages to zero. Reset release is synchronized over `RST_STAGES` system clocks. A capture clock that is already high at release causes no capture.
- R9: Both directions may be enabled at the same time, and each then operates independently of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the controls and clocks the storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Data observed on port A |
| a_drv | input | WIDTH | Per-bit flag, 1 when port A bit is actively driven |
| a_out | output | WIDTH | Data the block drives onto port A (0 when disabled) |
| a_oe | output | 1 | Port A output enable |
| b_in | input | WIDTH | Data observed on port B |
| b_drv | input | WIDTH | Per-bit flag, 1 when port B bit is actively driven |
| b_out | output | WIDTH | Data the block drives onto port B (0 when disabled) |
| b_oe | output | 1 | Port B output enable |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B capture clock, sampled by `clk` |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A capture clock, sampled by `clk` |

## Verification
A corrupted stored word shows on the far port in the first cycle that the output is enabled with the latch enable low. It stays visible until the next capture or transparent phase overwrites it. A capture-clock edge detector that is stuck or shifted shows one system cycle after the capture edge: the old word remains, or a spurious word appears when the latch enable falls or when reset releases. Held bus levels and their absence are visible in the same cycle that a bit stops being driven, as long as the direction is transparent.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    OE_HIGH = 1'b0,
    OE_LOW  = 1'b1
  } oe_pol_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int WIDTH  = 18,
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin,
  input  logic [WIDTH-1:0] drv,
  output logic [WIDTH-1:0] eff
);
  generate
    if (ENABLE) begin : g_hold
      logic [WIDTH-1:0] hold_q;
      logic [WIDTH-1:0] hold_d;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
          hold_d[i] = drv[i] ? pin[i] : hold_q[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) hold_q[i] <= 1'b0;
          else        hold_q[i] <= hold_d[i];
        end
        assign eff[i] = drv[i] ? pin[i] : hold_q[i];
      end
    end else begin : g_plain
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign eff = pin & drv;
    end
  endgenerate
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int      WIDTH  = 18,
  parameter oe_pol_e OE_POL = OE_HIGH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             oe_ctl,
  input  logic             le,
  input  logic             cap_clk,
  output logic [WIDTH-1:0] dout,
  output logic             oe
);
  logic             cap_clk_q;
  logic             cap_rise;
  logic             store_en;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;
  logic             oe_act;

  // Edge detector: armed high at reset so a clock already high causes no load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_clk_q <= 1'b1;
    else        cap_clk_q <= cap_clk;
  end

  always_comb begin
    cap_rise = cap_clk & ~cap_clk_q;
    store_en = le | cap_rise;
    store_d  = store_en ? din : store_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_d;
  end

  generate
    if (OE_POL == OE_HIGH) begin : g_oe_hi
      assign oe_act = oe_ctl;
    end else begin : g_oe_lo
      assign oe_act = ~oe_ctl;
    end
  endgenerate

  always_comb begin
    oe   = oe_act;
    dout = '0;
    if (oe_act) dout = le ? din : store_q;
  end
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH      = 18,
  parameter bit BUS_HOLD   = 1'b1,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] a_drv,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] b_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_oe,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_clk
);
  logic             rst_n_sync;
  logic [WIDTH-1:0] a_eff;
  logic [WIDTH-1:0] b_eff;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  xcvr_bus_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_a (
    .clk(clk), .rst_n(rst_n_sync), .pin(a_in), .drv(a_drv), .eff(a_eff)
  );

  xcvr_bus_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_b (
    .clk(clk), .rst_n(rst_n_sync), .pin(b_in), .drv(b_drv), .eff(b_eff)
  );

  xcvr_lane #(.WIDTH(WIDTH), .OE_POL(OE_HIGH)) u_lane_ab (
    .clk(clk), .rst_n(rst_n_sync), .din(a_eff), .oe_ctl(ab_oe),
    .le(ab_le), .cap_clk(ab_clk), .dout(b_out), .oe(b_oe)
  );

  xcvr_lane #(.WIDTH(WIDTH), .OE_POL(OE_LOW)) u_lane_ba (
    .clk(clk), .rst_n(rst_n_sync), .din(b_eff), .oe_ctl(ba_oe_n),
    .le(ba_le), .cap_clk(ba_clk), .dout(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_drv,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             ab_oe,
  input logic             ab_le,
  input logic             ab_clk,
  input logic             ba_oe_n
);
  AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ab_oe && ab_le && (&a_drv)) |-> (b_out == a_in)); // R1

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(rst_n_sync) && !ab_le && ab_clk && !$past(ab_clk) && (&a_drv))
    |=> (!ab_oe || ab_le || b_out == $past(a_in))); // R2

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(rst_n_sync) && ab_oe && !ab_le && !(ab_clk && !$past(ab_clk)))
    |=> (!ab_oe || ab_le || $stable(b_out))); // R3

  AST_AB_OFF: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !ab_oe |-> (!b_oe && b_out == '0)); // R5

  AST_BA_OFF: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ba_oe_n |-> (!a_oe && a_out == '0)); // R6

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($rose(rst_n_sync) && ab_oe && !ab_le) |-> (b_out == '0)); // R8
endmodule

bind bidir_reg_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .a_in(a_in), .a_drv(a_drv),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk), .ba_oe_n(ba_oe_n)
);

// File: tb/bidir_reg_xcvr_bench.sv
`timescale 1ns/1ps
module bidir_reg_xcvr_bench;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, a_drv, b_in, b_drv;
  logic ab_oe, ab_le, ab_clk, ba_oe_n, ba_le, ba_clk;
  logic [W-1:0] a_out, b_out, a_out_nh, b_out_nh;
  logic a_oe, b_oe, a_oe_nh, b_oe_nh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bidir_reg_xcvr #(.WIDTH(W), .BUS_HOLD(1'b1)) u_bidir_reg_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk), .ba_oe_n(ba_oe_n),
    .ba_le(ba_le), .ba_clk(ba_clk)
  );

  bidir_reg_xcvr #(.WIDTH(W), .BUS_HOLD(1'b0)) u_bidir_reg_xcvr_nohold (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv), .a_out(a_out_nh),
    .a_oe(a_oe_nh), .b_in(b_in), .b_drv(b_drv), .b_out(b_out_nh), .b_oe(b_oe_nh),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk), .ba_oe_n(ba_oe_n),
    .ba_le(ba_le), .ba_clk(ba_clk)
  );

  function automatic logic [W-1:0] pat(int i);
    logic [31:0] v;
    v = (i * 32'h0001_3579 + 32'h2A5) ^ (i << 7);
    return v[W-1:0];
  endfunction

  task automatic chk(logic [W-1:0] act, logic [W-1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    logic [W-1:0] p;
    rst_n = 1'b0;
    a_in = pat(3); b_in = pat(5); a_drv = ONES; b_drv = ONES;
    ab_oe = 1'b1; ab_le = 1'b0; ab_clk = 1'b0;
    ba_oe_n = 1'b0; ba_le = 1'b0; ba_clk = 1'b0;
    step(); step(); step();
    // R8: storage clear during reset
    chk(b_out, '0, "R8 reset b_out");
    chk(a_out, '0, "R8 reset a_out");
    // R8: capture clocks high at release must not load
    ab_clk = 1'b1; ba_clk = 1'b1;
    rst_n = 1'b1;
    step(); step(); step(); step();
    chk(b_out, '0, "R8 no load at release b_out");
    chk(a_out, '0, "R8 no load at release a_out");
    // R2: first real edge after release
    ab_clk = 1'b0; step();
    ab_clk = 1'b1; step();
    chk(b_out, pat(3), "R2 first capture");

    // R1 and R9: both directions transparent together
    ab_le = 1'b1; ba_le = 1'b1;
    for (int i = 0; i < 64; i++) begin
      a_in = pat(i); b_in = pat(i + 100);
      #1;
      chk(b_out, pat(i), "R1 transparent A to B");
      chk(a_out, pat(i + 100), "R9 B to A while A to B active");
      step();
    end

    // R4: latch-enable fall keeps last transparent value, clock low
    ab_clk = 1'b0; a_in = pat(200); step();
    ab_le = 1'b0; a_in = pat(201); #1;
    chk(b_out, pat(200), "R4 keep after le fall");
    step(); step();
    chk(b_out, pat(200), "R4 no capture from le fall");
    // R4: clock already high when le falls
    ab_le = 1'b1; ab_clk = 1'b1; a_in = pat(202); step();
    ab_le = 1'b0; a_in = pat(203); step(); step();
    chk(b_out, pat(202), "R4 clock high across le fall");

    // R3: steady clock high, then low
    held = pat(202);
    for (int i = 0; i < 8; i++) begin
      ab_clk = (i >= 4) ? 1'b0 : 1'b1;
      a_in = pat(300 + i); step();
      chk(b_out, held, "R3 hold with steady clock");
    end

    // R2 sweep
    for (int i = 0; i < 32; i++) begin
      ab_clk = 1'b0; a_in = pat(400 + i); step();
      ab_clk = 1'b1; step();
      chk(b_out, pat(400 + i), "R2 capture on rising clock");
      a_in = ~pat(400 + i); step();
      chk(b_out, pat(400 + i), "R3 hold after capture");
    end

    // R5: disabled output, load while disabled
    ab_oe = 1'b0; #1;
    chk(b_out, '0, "R5 b_out zero when disabled");
    chk({{(W-1){1'b0}}, b_oe}, '0, "R5 b_oe low");
    ab_clk = 1'b0; a_in = pat(500); step();
    ab_clk = 1'b1; step();
    a_in = pat(501); ab_oe = 1'b1; #1;
    chk(b_out, pat(500), "R5 loaded while disabled");
    chk({{(W-1){1'b0}}, b_oe}, 1, "R5 b_oe high");

    // R6: B-to-A capture and active-low enable
    ba_le = 1'b0; ba_clk = 1'b0; b_in = pat(600); step();
    ba_clk = 1'b1; step();
    b_in = pat(601); step();
    chk(a_out, pat(600), "R6 B to A capture");
    ba_oe_n = 1'b1; #1;
    chk(a_out, '0, "R6 a_out zero when ba_oe_n high");
    chk({{(W-1){1'b0}}, a_oe}, '0, "R6 a_oe low");
    ba_oe_n = 1'b0; #1;
    chk(a_out, pat(600), "R6 re-enabled shows stored");

    // R7: bus hold on undriven bits
    ab_le = 1'b1;
    for (int k = 0; k < 4; k++) begin
      p = pat(700 + k);
      a_drv = ONES; a_in = p; step();
      a_drv = ONES << (k + 1); a_in = ~p; #1;
      chk(b_out, (p & ~a_drv) | (~p & a_drv), "R7 held level with bus hold");
      chk(b_out_nh, ~p & a_drv, "R7 undriven reads zero without hold");
      step();
      chk(b_out, (p & ~a_drv) | (~p & a_drv), "R7 held level stays");
    end
    a_drv = ONES;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule